// File: doc/BRIEF.md
# Supply Status and Output Gating Controller

This synchronous controller watches three digitized voltages, each given as a millivolt code: the main supply, the backup battery and a power-fail sense input. It takes new codes only on cycles where a valid strobe is high. From each accepted sample it decides whether memory power comes from the main supply or from the battery. It also keeps a low-line flag with hysteresis and a plain power-fail comparison. All thresholds and hysteresis bands are applied digitally to the codes.

The registered outputs serve the rest of the system. A battery-on indicator shows the current power source. An active-low low-line flag reports a weak or absent supply. The active-low memory chip-enable is gated so that memory cannot be selected during a brown-out, and the power-fail warning is gated too. A supply-healthy status flag goes to the reset and watchdog timer, which holds reset while this flag is low. In backup mode every output takes a fixed safe value, whatever the chip-enable and sense inputs are doing. After reset the block starts in backup mode and stays there until a sample proves the supply good.

Top module: `supply_gate_ctrl`

## Requirements
- R1: While reset is high and after it until the first accepted sample: `on_battery`=1, `low_line_n`=0, `ce_out_n`=1, `pf_out`=0, `supply_ok`=0.
- R2: In backup mode, an accepted sample with supply code minus battery code of at least 70 selects main-supply mode from the next cycle.
- R3: In main mode, an accepted sample with supply minus battery of 50 or less (including negative margins) selects backup mode. Margins of 51 to 69 leave the mode unchanged.
- R4: An accepted supply code below 2900 sets the below-threshold state. Only a code above 2940 clears it. Codes from 2900 to 2940 leave it unchanged.
- R5: `low_line_n` is 0 whenever the block is below threshold or in backup mode. Since backup mode is entered before the supply drops under the battery, low-line is also low whenever the supply is below the battery.
- R6: `on_battery` is 1 in backup mode and 0 in main mode, and it changes in the cycle after the deciding sample.
- R7: `ce_out_n` equals the `ce_in_n` value sampled at the previous clock edge when the post-edge state is main mode and not below threshold. Otherwise it is forced to 1.
- R8: `pf_out` is 1 when the last accepted sense code is 1300 or more and 0 when it is below 1300. There is no hysteresis, and the output is forced to 0 in backup mode.
- R9: `supply_ok` is 1 exactly when the block is in main mode and not below threshold.
- R10: Codes presented while `sample_valid` is low change no output other than `ce_out_n` following `ce_in_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe marking the three codes as a new sample |
| vcc_mv | input | CODE_W | Main supply code in millivolts |
| bat_mv | input | CODE_W | Battery code in millivolts |
| sense_mv | input | CODE_W | Power-fail sense code in millivolts |
| ce_in_n | input | 1 | Active-low chip-enable request from the address decoder |
| on_battery | output | 1 | 1 while memory power is taken from the battery |
| low_line_n | output | 1 | Active-low low-supply flag |
| ce_out_n | output | 1 | Gated active-low chip-enable to memory |
| pf_out | output | 1 | Power-fail warning, 0 means failing |
| supply_ok | output | 1 | Status to the reset/watchdog timer, 0 holds reset |

## Verification
The switchover is driven with margins of exactly 50, 51, 69 and 70 mV, from both modes. These separate the two asymmetric edges from the hold band. The supply is stepped through 2899, 2900, 2940 and 2941 with falling and rising histories, which shows that low-line depends on history and not only on the current code. Sense codes of 1299 and 1300 are applied in both modes, and the chip-enable is toggled in healthy, brown-out and backup states to test the gating. Extreme codes are offered with the strobe low to show they are ignored, and a long stretch of random samples tries out the combinations, all compared against a behavioural model on every clock.

// File: rtl/supsw_pkg.sv
package supsw_pkg;
  typedef enum logic {
    MODE_MAIN   = 1'b0,
    MODE_BACKUP = 1'b1
  } supply_mode_e;

  typedef struct packed {
    logic on_battery;
    logic low_line_n;
    logic pf_out;
    logic supply_ok;
  } status_t;

  localparam status_t STATUS_SAFE = '{
    on_battery: 1'b1,
    low_line_n: 1'b0,
    pf_out:     1'b0,
    supply_ok:  1'b0
  };
endpackage

// File: rtl/supsw_switchover.sv
module supsw_switchover
  import supsw_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int SW_UP_MV  = 70,
  parameter int SW_DN_MV  = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] vcc_mv,
  input  logic [CODE_W-1:0] bat_mv,
  output supply_mode_e      mode_next,
  output supply_mode_e      mode_q
);
  localparam int DW = CODE_W + 1;

  logic signed [DW-1:0] margin;
  int                   margin_i;

  assign margin   = $signed({1'b0, vcc_mv}) - $signed({1'b0, bat_mv});
  assign margin_i = int'(margin);

  always_comb begin
    mode_next = mode_q;
    if (sample_valid) begin
      if (mode_q == MODE_BACKUP && margin_i >= SW_UP_MV)
        mode_next = MODE_MAIN;
      else if (mode_q == MODE_MAIN && margin_i <= SW_DN_MV)
        mode_next = MODE_BACKUP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_BACKUP;
    else     mode_q <= mode_next;
  end

  assert_go_main_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && mode_q == MODE_BACKUP && margin_i >= SW_UP_MV) |=> (mode_q == MODE_MAIN));

  assert_go_backup_R3: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && mode_q == MODE_MAIN && margin_i <= SW_DN_MV) |=> (mode_q == MODE_BACKUP));

  assert_hold_band_R3: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && margin_i > SW_DN_MV && margin_i < SW_UP_MV) |=> $stable(mode_q));
endmodule

// File: rtl/supsw_lowline.sv
module supsw_lowline #(
  parameter int CODE_W       = 12,
  parameter int TH_RESET_MV  = 2900,
  parameter int HYS_RESET_MV = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] vcc_mv,
  output logic              below_next,
  output logic              below_q
);
  localparam int TH_RELEASE = TH_RESET_MV + HYS_RESET_MV;

  int vcc_i;
  assign vcc_i = int'({1'b0, vcc_mv});

  always_comb begin
    below_next = below_q;
    if (sample_valid) begin
      if (vcc_i < TH_RESET_MV)      below_next = 1'b1;
      else if (vcc_i > TH_RELEASE)  below_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) below_q <= 1'b1;
    else     below_q <= below_next;
  end

  assert_trip_R4: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && vcc_i < TH_RESET_MV) |=> below_q);

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && vcc_i > TH_RELEASE) |=> !below_q);

  assert_band_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && vcc_i >= TH_RESET_MV && vcc_i <= TH_RELEASE) |=> $stable(below_q));
endmodule

// File: rtl/supsw_pfcmp.sv
module supsw_pfcmp #(
  parameter int CODE_W   = 12,
  parameter int PF_TH_MV = 1300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] sense_mv,
  output logic              pf_good_next
);
  logic pf_good_q;
  int   sense_i;

  assign sense_i      = int'({1'b0, sense_mv});
  assign pf_good_next = sample_valid ? (sense_i >= PF_TH_MV) : pf_good_q;

  always_ff @(posedge clk) begin
    if (rst) pf_good_q <= 1'b0;
    else     pf_good_q <= pf_good_next;
  end

  assert_no_hys_R8: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && sense_i < PF_TH_MV) |=> !pf_good_q);
endmodule

// File: rtl/supsw_outgate.sv
module supsw_outgate
  import supsw_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  supply_mode_e mode_next,
  input  logic         below_next,
  input  logic         pf_good_next,
  input  logic         ce_in_n,
  output logic         on_battery,
  output logic         low_line_n,
  output logic         ce_out_n,
  output logic         pf_out,
  output logic         supply_ok
);
  status_t st_next, st_q;
  logic    healthy_next;

  assign healthy_next = (mode_next == MODE_MAIN) && !below_next;

  always_comb begin
    if (mode_next == MODE_BACKUP) begin
      st_next = STATUS_SAFE;
    end else begin
      st_next.on_battery = 1'b0;
      st_next.low_line_n = !below_next;
      st_next.pf_out     = pf_good_next;
      st_next.supply_ok  = healthy_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= STATUS_SAFE;
      ce_out_n <= 1'b1;
    end else begin
      st_q     <= st_next;
      ce_out_n <= ce_in_n | !healthy_next;
    end
  end

  assign on_battery = st_q.on_battery;
  assign low_line_n = st_q.low_line_n;
  assign pf_out     = st_q.pf_out;
  assign supply_ok  = st_q.supply_ok;

  assert_safe_state_R5: assert property (@(posedge clk) disable iff (rst)
    on_battery |-> (!low_line_n && !pf_out && !supply_ok && ce_out_n));

  assert_ce_block_R7: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |-> ce_out_n);

  assert_ok_lowline_R9: assert property (@(posedge clk) disable iff (rst)
    supply_ok |-> (low_line_n && !on_battery));
endmodule

// File: rtl/supply_gate_ctrl.sv
module supply_gate_ctrl
  import supsw_pkg::*;
#(
  parameter int CODE_W       = 12,
  parameter int SW_UP_MV     = 70,
  parameter int SW_DN_MV     = 50,
  parameter int TH_RESET_MV  = 2900,
  parameter int HYS_RESET_MV = 40,
  parameter int PF_TH_MV     = 1300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] vcc_mv,
  input  logic [CODE_W-1:0] bat_mv,
  input  logic [CODE_W-1:0] sense_mv,
  input  logic              ce_in_n,
  output logic              on_battery,
  output logic              low_line_n,
  output logic              ce_out_n,
  output logic              pf_out,
  output logic              supply_ok
);
  supply_mode_e mode_next, mode_q;
  logic         below_next, below_q;
  logic         pf_good_next;

  supsw_switchover #(
    .CODE_W(CODE_W), .SW_UP_MV(SW_UP_MV), .SW_DN_MV(SW_DN_MV)
  ) u_switch (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .vcc_mv(vcc_mv), .bat_mv(bat_mv),
    .mode_next(mode_next), .mode_q(mode_q)
  );

  supsw_lowline #(
    .CODE_W(CODE_W), .TH_RESET_MV(TH_RESET_MV), .HYS_RESET_MV(HYS_RESET_MV)
  ) u_lowline (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .vcc_mv(vcc_mv), .below_next(below_next), .below_q(below_q)
  );

  supsw_pfcmp #(
    .CODE_W(CODE_W), .PF_TH_MV(PF_TH_MV)
  ) u_pf (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .sense_mv(sense_mv), .pf_good_next(pf_good_next)
  );

  supsw_outgate u_gate (
    .clk(clk), .rst(rst),
    .mode_next(mode_next), .below_next(below_next), .pf_good_next(pf_good_next),
    .ce_in_n(ce_in_n),
    .on_battery(on_battery), .low_line_n(low_line_n), .ce_out_n(ce_out_n),
    .pf_out(pf_out), .supply_ok(supply_ok)
  );

  assert_mode_flag_R6: assert property (@(posedge clk) disable iff (rst)
    on_battery == (mode_q == MODE_BACKUP));

  assert_lowline_R5: assert property (@(posedge clk) disable iff (rst)
    low_line_n == !(below_q || mode_q == MODE_BACKUP));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> ($stable(on_battery) && $stable(low_line_n) && $stable(pf_out) && $stable(supply_ok)));
endmodule

// File: tb/tb_supply_gate_ctrl.sv
module tb_supply_gate_ctrl;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sample_valid = 1'b0;
  logic [W-1:0] vcc_mv = '0, bat_mv = '0, sense_mv = '0;
  logic         ce_in_n = 1'b1;
  logic         on_battery, low_line_n, ce_out_n, pf_out, supply_ok;

  int n_checks = 0, n_fail = 0, cyc = 0;
  string phase = "R1";

  // reference model state
  int m_batt = 1, m_below = 1, m_pf = 0;
  int e_bat = 1, e_ll = 0, e_ce = 1, e_pf = 0, e_ok = 0;

  always #4 clk = ~clk;

  supply_gate_ctrl dut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid),
    .vcc_mv(vcc_mv), .bat_mv(bat_mv), .sense_mv(sense_mv), .ce_in_n(ce_in_n),
    .on_battery(on_battery), .low_line_n(low_line_n), .ce_out_n(ce_out_n),
    .pf_out(pf_out), .supply_ok(supply_ok)
  );

  always @(posedge clk) begin
    int margin, v, s;
    cyc++;
    if (rst) begin
      m_batt = 1; m_below = 1; m_pf = 0;
    end else if (sample_valid) begin
      v = int'(vcc_mv); s = int'(sense_mv);
      margin = v - int'(bat_mv);
      if (m_batt == 1 && margin >= 70) m_batt = 0;
      else if (m_batt == 0 && margin <= 50) m_batt = 1;
      if (v < 2900) m_below = 1;
      else if (v > 2940) m_below = 0;
      m_pf = (s >= 1300) ? 1 : 0;
    end
    e_bat = m_batt;
    e_ll  = (m_batt == 1 || m_below == 1) ? 0 : 1;
    e_pf  = (m_batt == 1) ? 0 : m_pf;
    e_ok  = (m_batt == 0 && m_below == 0) ? 1 : 0;
    e_ce  = (rst || e_ok == 0) ? 1 : int'(ce_in_n);
  end

  task automatic chk(input string tag, input logic act, input int exp);
    n_checks++;
    if (int'(act) != exp) begin
      n_fail++;
      $display("FAIL %s [%s] cycle %0d: actual %0d expected %0d", tag, phase, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk("R6 R2 R3 on_battery", on_battery, e_bat);
      chk("R4 R5 low_line_n", low_line_n, e_ll);
      chk("R7 ce_out_n", ce_out_n, e_ce);
      chk("R8 pf_out", pf_out, e_pf);
      chk("R9 supply_ok", supply_ok, e_ok);
    end
  end

  task automatic smp(input int v, input int b, input int s);
    @(negedge clk);
    vcc_mv = W'(v); bat_mv = W'(b); sense_mv = W'(s);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(3);                         // R1: safe state persists without samples

    phase = "R2";
    smp(3300, 3240, 1500);           // margin 60: stay backup
    smp(3300, 3231, 1500);           // margin 69: stay backup
    smp(3300, 3230, 1500);           // margin 70: go main, healthy

    phase = "R7";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ce_in_n = i[0];
    end

    phase = "R8";
    smp(3300, 2400, 1299);
    smp(3300, 2400, 1300);
    smp(3300, 2400, 1299);

    phase = "R4";
    smp(2899, 2400, 1500);           // trip
    @(negedge clk); ce_in_n = 1'b0;  // brown-out blocks enable
    smp(2940, 2400, 1500);           // hold below
    smp(2900, 2400, 1500);
    smp(2941, 2400, 1500);           // release
    smp(2900, 2400, 1500);           // hold released
    smp(2940, 2400, 1500);

    phase = "R3";
    smp(3000, 2949, 1500);           // margin 51 hold main
    smp(3000, 2950, 1500);           // margin 50 backup
    @(negedge clk); ce_in_n = 1'b0;
    smp(3000, 2931, 1500);           // margin 69 hold backup
    smp(3000, 2930, 1500);           // back to main
    smp(2000, 2400, 1500);           // supply below battery, R5

    phase = "R10";
    smp(3300, 2000, 1500);
    @(negedge clk);
    vcc_mv = W'(100); bat_mv = W'(3000); sense_mv = W'(0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ce_in_n = ~ce_in_n;
    end
    vcc_mv = W'(4000); bat_mv = W'(0); sense_mv = W'(4000);
    smp(2000, 2400, 100);
    idle(2);
    vcc_mv = W'(3500); bat_mv = W'(0);
    idle(4);

    phase = "RAND";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      vcc_mv   = W'($urandom_range(2800, 3100));
      bat_mv   = W'($urandom_range(2700, 3050));
      sense_mv = W'($urandom_range(1250, 1350));
      ce_in_n  = 1'($urandom_range(0, 1));
      sample_valid = 1'($urandom_range(0, 2) != 0);
    end
    sample_valid = 1'b0;

    phase = "R1";
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog [%s]: actual hung expected finished", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule